// File: doc/BRIEF.md
# PMP Access Permission Checker

A purely combinational physical-memory-protection checker for one access port. It receives the sixteen protection entries (one configuration byte and one 32-bit address word each), the two security-policy flags, the privilege of the requester (machine or not), and the access itself: its start address, its length in bytes and the set of access types requested. It answers in the same cycle with the permission set that applies, a grant flag, the index of the deciding entry and a flag saying that no entry decided.

Each entry's address word is turned into an inclusive byte range over a 34-bit physical space. Three encodings are supported: top-of-range, a fixed 4-byte naturally aligned window, and a power-of-two window coded by trailing ones. Entries are scanned from the lowest index. The first entry that is enabled and covers the whole access decides. An entry that covers only one end of the access denies it at once. Permissions come either from the entry's own bits or, when the lockdown policy is active, from a sixteen-way truth table indexed by the lock and permission bits.

Top module: `pmp_access_checker`

## Requirements
- R1: Each configuration byte holds read in bit 0, write in bit 1, execute in bit 2, the match mode in bits 4:3 (0 disabled, 1 top-of-range, 2 four-byte window, 3 power-of-two window) and lock in bit 7. A disabled entry never decides. The allowed-set output and the request input both use bit 0 = read, bit 1 = write, bit 2 = execute.
- R2: A top-of-range entry covers `prev<<2` to `(own<<2)-1`, computed modulo 2^34, with `prev` taken as zero for entry 0. If the start lies above the end, the entry covers byte 0 only.
- R3: A four-byte entry covers `own<<2` to `(own<<2)+3`.
- R4: A power-of-two entry forms `t = {own, 2'b11}` and covers `t & (t+1)` to `t | (t+1)`.
- R5: Among entries that are enabled and contain both the first and the last byte, the lowest index decides.
- R6: If, scanning upward, an entry contains exactly one of the first and last bytes before any entry decides, the access is denied: allowed set 0, grant 0, default flag 0, and index = that entry.
- R7: With lockdown clear, a deciding entry gives machine mode read, write and execute unless the entry is locked. In every other case the allowed set is the entry's own read, write and execute bits.
- R8: With lockdown set and machine mode, the key {lock, read, write, execute} (lock is the MSB) maps as follows: 2, 3 and 14 give read-write; 9 and 10 give execute; 11 and 13 give read-execute; 12 and 15 give read; every other key gives nothing.
- R9: With lockdown set and a lower mode, the same key maps as follows: 1, 10 and 11 give execute; 2, 4 and 15 give read; 3 and 6 give read-write; 5 gives read-execute; 7 gives all three; every other key gives nothing.
- R10: When no entry decides, the outcome depends on the policy flags. The whitelist flag denies everything. Otherwise lockdown gives machine mode read-write only when execute is not requested, and gives lower modes nothing. With neither flag, machine mode gets all three and lower modes get nothing.
- R11: Grant is 1 exactly when no partial overlap occurred and every requested type is in the allowed set.
- R12: A size of zero means 4 bytes. The last byte is `addr + size - 1`, wrapped modulo 2^32.
- R13: When no entry decides and no partial overlap occurs, the default flag is 1 and the index is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| cfg_i | input | N*8 | Configuration bytes, entry i at bits [8i+7:8i] |
| addr_i | input | N*AW | Address words, entry i at bits [AW*i+AW-1:AW*i] |
| mmode_i | input | 1 | Requester runs in machine mode |
| lockdown_i | input | 1 | Lockdown policy active |
| whitelist_i | input | 1 | Deny-by-default policy active |
| acc_addr_i | input | AW | First byte address of the access |
| acc_size_i | input | SW | Access length in bytes, 0 means 4 |
| req_i | input | 3 | Requested types: bit0 read, bit1 write, bit2 execute |
| allowed_o | output | 3 | Permitted types, same bit order |
| grant_o | output | 1 | All requested types permitted |
| match_idx_o | output | $clog2(N) | Deciding or straddled entry index |
| default_o | output | 1 | No entry decided; policy default applied |

## Verification
All four results are combinational, so each one is valid in the same cycle its inputs change and no register lies on any path. The bench changes the inputs at the falling clock edge and compares the outputs 2 ns later, well before the next rising edge. Nothing is carried from one vector to the next, so every vector is judged by itself, and reordering the vectors cannot hide a fault.

// File: rtl/pmp_chk_pkg.sv
package pmp_chk_pkg;

  typedef enum logic [1:0] {
    AM_OFF   = 2'd0,
    AM_TOR   = 2'd1,
    AM_NA4   = 2'd2,
    AM_NAPOT = 2'd3
  } amode_e;

  typedef struct packed {
    logic       lck;
    logic [1:0] rsvd;
    amode_e     am;
    logic       x;
    logic       w;
    logic       r;
  } cfg_t;

  typedef struct packed {
    logic x;
    logic w;
    logic r;
  } perm_t;

  localparam perm_t PERM_NONE = 3'b000;
  localparam perm_t PERM_R    = 3'b001;
  localparam perm_t PERM_RW   = 3'b011;
  localparam perm_t PERM_X    = 3'b100;
  localparam perm_t PERM_RX   = 3'b101;
  localparam perm_t PERM_ALL  = 3'b111;

endpackage

// File: rtl/pmp_range_decode.sv
module pmp_range_decode
  import pmp_chk_pkg::*;
#(
  parameter int unsigned AW = 32
) (
  input  cfg_t            cfg_i,
  input  logic [AW-1:0]   own_i,
  input  logic [AW-1:0]   prev_i,
  output logic [AW+1:0]   lo_o,
  output logic [AW+1:0]   hi_o,
  output logic            on_o
);
  localparam int unsigned RW = AW + 2;

  logic [RW-1:0] own_s, prev_s, tor_hi, nap, nap_inc;

  assign own_s   = {own_i, 2'b00};
  assign prev_s  = {prev_i, 2'b00};
  assign tor_hi  = own_s - RW'(1);
  assign nap     = {own_i, 2'b11};
  assign nap_inc = nap + RW'(1);
  assign on_o    = (cfg_i.am != AM_OFF);

  always_comb begin
    unique case (cfg_i.am)
      AM_TOR: begin
        if (prev_s > tor_hi) begin
          lo_o = '0;
          hi_o = '0;
        end else begin
          lo_o = prev_s;
          hi_o = tor_hi;
        end
      end
      AM_NA4: begin
        lo_o = own_s;
        hi_o = own_s | RW'(3);
      end
      AM_NAPOT: begin
        lo_o = nap & nap_inc;
        hi_o = nap | nap_inc;
      end
      default: begin
        lo_o = '0;
        hi_o = '1;
      end
    endcase
  end

endmodule

// File: rtl/pmp_prio_select.sv
module pmp_prio_select #(
  parameter int unsigned N  = 16,
  parameter int unsigned AW = 32,
  localparam int unsigned IW = $clog2(N)
) (
  input  logic [N-1:0][AW+1:0] lo_i,
  input  logic [N-1:0][AW+1:0] hi_i,
  input  logic [N-1:0]         on_i,
  input  logic [AW-1:0]        first_i,
  input  logic [AW-1:0]        last_i,
  output logic                 sel_o,
  output logic                 partial_o,
  output logic [IW-1:0]        idx_o
);
  logic [AW+1:0] first_x, last_x;
  logic [N-1:0]  fin, lin, stop;

  assign first_x = {2'b00, first_i};
  assign last_x  = {2'b00, last_i};

  for (genvar g = 0; g < N; g++) begin : g_hit
    assign fin[g]  = (first_x >= lo_i[g]) && (first_x <= hi_i[g]);
    assign lin[g]  = (last_x  >= lo_i[g]) && (last_x  <= hi_i[g]);
    assign stop[g] = (fin[g] ^ lin[g]) | (fin[g] & lin[g] & on_i[g]);
  end

  // lowest stopping index wins
  always_comb begin
    sel_o     = 1'b0;
    partial_o = 1'b0;
    idx_o     = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (stop[i]) begin
        sel_o     = 1'b1;
        partial_o = fin[i] ^ lin[i];
        idx_o     = IW'(i);
      end
    end
  end

endmodule

// File: rtl/pmp_perm_eval.sv
module pmp_perm_eval
  import pmp_chk_pkg::*;
(
  input  cfg_t  cfg_i,
  input  logic  full_i,
  input  logic  partial_i,
  input  logic  mmode_i,
  input  logic  lockdown_i,
  input  logic  whitelist_i,
  input  perm_t req_i,
  output perm_t allowed_o,
  output logic  grant_o,
  output logic  dflt_o
);

  function automatic perm_t tbl_mach(input logic [3:0] k);
    unique case (k)
      4'd2, 4'd3, 4'd14: return PERM_RW;
      4'd9, 4'd10:       return PERM_X;
      4'd11, 4'd13:      return PERM_RX;
      4'd12, 4'd15:      return PERM_R;
      default:           return PERM_NONE;
    endcase
  endfunction

  function automatic perm_t tbl_low(input logic [3:0] k);
    unique case (k)
      4'd1, 4'd10, 4'd11: return PERM_X;
      4'd2, 4'd4, 4'd15:  return PERM_R;
      4'd3, 4'd6:         return PERM_RW;
      4'd5:               return PERM_RX;
      4'd7:               return PERM_ALL;
      default:            return PERM_NONE;
    endcase
  endfunction

  logic [3:0] key;
  perm_t      own_perm;

  assign key      = {cfg_i.lck, cfg_i.r, cfg_i.w, cfg_i.x};
  assign own_perm = {cfg_i.x, cfg_i.w, cfg_i.r};
  assign dflt_o   = !full_i && !partial_i;

  always_comb begin
    if (partial_i) begin
      allowed_o = PERM_NONE;
    end else if (full_i) begin
      if (!lockdown_i) allowed_o = (mmode_i && !cfg_i.lck) ? PERM_ALL : own_perm;
      else if (mmode_i) allowed_o = tbl_mach(key);
      else allowed_o = tbl_low(key);
    end else if (whitelist_i) begin
      allowed_o = PERM_NONE;
    end else if (lockdown_i) begin
      allowed_o = (mmode_i && !req_i.x) ? PERM_RW : PERM_NONE;
    end else begin
      allowed_o = mmode_i ? PERM_ALL : PERM_NONE;
    end
  end

  assign grant_o = !partial_i && ((req_i & ~allowed_o) == 3'b000);

endmodule

// File: rtl/pmp_access_checker.sv
module pmp_access_checker
  import pmp_chk_pkg::*;
#(
  parameter int unsigned N  = 16,
  parameter int unsigned AW = 32,
  parameter int unsigned SW = 4
) (
  input  logic [N*8-1:0]       cfg_i,
  input  logic [N*AW-1:0]      addr_i,
  input  logic                 mmode_i,
  input  logic                 lockdown_i,
  input  logic                 whitelist_i,
  input  logic [AW-1:0]        acc_addr_i,
  input  logic [SW-1:0]        acc_size_i,
  input  logic [2:0]           req_i,
  output logic [2:0]           allowed_o,
  output logic                 grant_o,
  output logic [$clog2(N)-1:0] match_idx_o,
  output logic                 default_o
);
  localparam int unsigned IW = $clog2(N);

  cfg_t                  cfg_a [N];
  logic [N-1:0][AW+1:0]  lo, hi;
  logic [N-1:0]          on;
  logic [SW-1:0]         size_eff;
  logic [AW-1:0]         last_b;
  logic                  sel, partial;
  logic [IW-1:0]         idx;
  perm_t                 allowed;

  assign size_eff = (acc_size_i == '0) ? SW'(4) : acc_size_i;
  assign last_b   = acc_addr_i + AW'(size_eff) - AW'(1);

  for (genvar g = 0; g < N; g++) begin : g_ent
    logic [AW-1:0] prev;
    assign cfg_a[g] = cfg_t'(cfg_i[g*8 +: 8]);
    if (g == 0) begin : g_first
      assign prev = '0;
    end else begin : g_rest
      assign prev = addr_i[(g-1)*AW +: AW];
    end
    pmp_range_decode #(.AW(AW)) u_dec (
      .cfg_i  (cfg_a[g]),
      .own_i  (addr_i[g*AW +: AW]),
      .prev_i (prev),
      .lo_o   (lo[g]),
      .hi_o   (hi[g]),
      .on_o   (on[g])
    );
  end

  pmp_prio_select #(.N(N), .AW(AW)) u_sel (
    .lo_i      (lo),
    .hi_i      (hi),
    .on_i      (on),
    .first_i   (acc_addr_i),
    .last_i    (last_b),
    .sel_o     (sel),
    .partial_o (partial),
    .idx_o     (idx)
  );

  pmp_perm_eval u_perm (
    .cfg_i       (cfg_a[idx]),
    .full_i      (sel && !partial),
    .partial_i   (partial),
    .mmode_i     (mmode_i),
    .lockdown_i  (lockdown_i),
    .whitelist_i (whitelist_i),
    .req_i       (perm_t'(req_i)),
    .allowed_o   (allowed),
    .grant_o     (grant_o),
    .dflt_o      (default_o)
  );

  assign allowed_o   = allowed;
  assign match_idx_o = idx;

  always_comb begin
    if (grant_o) begin
      p_grant_subset_r11: assert ((req_i & ~allowed_o) == 3'b000)
        else $error("grant with missing permission");
    end
    if (partial) begin
      p_partial_deny_r6: assert (allowed_o == 3'b000 && !grant_o && !default_o)
        else $error("straddling access not denied");
    end
    if (default_o && whitelist_i) begin
      p_whitelist_r10: assert (allowed_o == 3'b000)
        else $error("whitelist default leaked permission");
    end
    if (sel && !partial && !lockdown_i && !mmode_i) begin
      p_classic_low_r7: assert (allowed_o == {cfg_a[idx].x, cfg_a[idx].w, cfg_a[idx].r})
        else $error("lower mode did not get entry bits");
    end
    if (default_o) begin
      p_default_idx_r13: assert (match_idx_o == '0 && !sel)
        else $error("default with nonzero index or selection");
    end
  end

endmodule

// File: tb/tb_pmp_access_checker.sv
module tb_pmp_access_checker;
  localparam int N = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic [7:0]  cfg_q [N];
  logic [31:0] adr_q [N];
  logic [N*8-1:0]  cfg_bus;
  logic [N*32-1:0] adr_bus;
  logic        md, lk, wl;
  logic [31:0] aa;
  logic [3:0]  sz;
  logic [2:0]  rq;
  logic [2:0]  allowed;
  logic        grant, dflt;
  logic [3:0]  idx;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      cfg_bus[i*8 +: 8]  = cfg_q[i];
      adr_bus[i*32 +: 32] = adr_q[i];
    end
  end

  pmp_access_checker dut (
    .cfg_i(cfg_bus), .addr_i(adr_bus), .mmode_i(md), .lockdown_i(lk),
    .whitelist_i(wl), .acc_addr_i(aa), .acc_size_i(sz), .req_i(rq),
    .allowed_o(allowed), .grant_o(grant), .match_idx_o(idx), .default_o(dflt)
  );

  function automatic logic [2:0] mach_tab(input logic [3:0] k);
    case (k)
      4'd2, 4'd3, 4'd14: return 3'b011;
      4'd9, 4'd10:       return 3'b100;
      4'd11, 4'd13:      return 3'b101;
      4'd12, 4'd15:      return 3'b001;
      default:           return 3'b000;
    endcase
  endfunction

  function automatic logic [2:0] low_tab(input logic [3:0] k);
    case (k)
      4'd7:               return 3'b111;
      4'd5:               return 3'b101;
      4'd3, 4'd6:         return 3'b011;
      4'd2, 4'd4, 4'd15:  return 3'b001;
      4'd1, 4'd10, 4'd11: return 3'b100;
      default:            return 3'b000;
    endcase
  endfunction

  // returns {default, idx, grant, allowed}
  function automatic logic [8:0] ref_eval();
    logic [63:0] m34, f, l, lo, hi, pv, ow, nv;
    logic [2:0] al;
    logic fi, li;
    int n;
    m34 = 64'h3_FFFF_FFFF;
    n = (sz == 0) ? 4 : int'(sz);
    f = 64'(aa);
    l = (64'(aa) + 64'(n) - 64'd1) & 64'hFFFF_FFFF;
    for (int i = 0; i < N; i++) begin
      if (cfg_q[i][4:3] == 2'd0) continue;
      ow = {30'd0, adr_q[i], 2'b00};
      pv = 64'd0;
      if (i > 0) pv = {30'd0, adr_q[i-1], 2'b00};
      case (cfg_q[i][4:3])
        2'd1: begin
          lo = pv; hi = (ow - 64'd1) & m34;
          if (lo > hi) begin lo = 0; hi = 0; end
        end
        2'd2: begin lo = ow; hi = ow + 64'd3; end
        default: begin
          nv = {30'd0, adr_q[i], 2'b11};
          lo = nv & ((nv + 64'd1) & m34);
          hi = (nv | (nv + 64'd1)) & m34;
        end
      endcase
      fi = (f >= lo) && (f <= hi);
      li = (l >= lo) && (l <= hi);
      if (fi != li) return {1'b0, 4'(i), 1'b0, 3'b000};
      if (fi) begin
        if (!lk) al = (md && !cfg_q[i][7]) ? 3'b111 : cfg_q[i][2:0];
        else if (md) al = mach_tab({cfg_q[i][7], cfg_q[i][0], cfg_q[i][1], cfg_q[i][2]});
        else al = low_tab({cfg_q[i][7], cfg_q[i][0], cfg_q[i][1], cfg_q[i][2]});
        return {1'b0, 4'(i), ((rq & ~al) == 3'b000), al};
      end
    end
    if (wl) al = 3'b000;
    else if (lk) al = (md && !rq[2]) ? 3'b011 : 3'b000;
    else al = md ? 3'b111 : 3'b000;
    return {1'b1, 4'd0, ((rq & ~al) == 3'b000), al};
  endfunction

  task automatic clear_all();
    for (int i = 0; i < N; i++) begin
      cfg_q[i] = 8'h00;
      adr_q[i] = 32'h0;
    end
    md = 0; lk = 0; wl = 0;
  endtask

  task automatic apply(input logic m, input logic [31:0] a, input logic [3:0] s, input logic [2:0] r);
    @(negedge clk);
    md = m; aa = a; sz = s; rq = r;
    #2;
  endtask

  task automatic check(input string tag, input logic [2:0] ea, input logic eg,
                       input logic [3:0] ei, input logic ed);
    n_chk++;
    if (allowed !== ea || grant !== eg || idx !== ei || dflt !== ed) begin
      n_bad++;
      $display("FAIL %s: got allowed=%b grant=%b idx=%0d dflt=%b exp allowed=%b grant=%b idx=%0d dflt=%b",
               tag, allowed, grant, idx, dflt, ea, eg, ei, ed);
    end
  endtask

  task automatic check_ref(input string tag);
    logic [8:0] e;
    e = ref_eval();
    check(tag, e[2:0], e[3], e[7:4], e[8]);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    clear_all();
    aa = 0; sz = 0; rq = 0;
    repeat (3) @(posedge clk);
    rst_n = 1'b1;

    // reset-like state: nothing enabled
    apply(1, 32'h100, 4'd4, 3'b001); check("R13 all off machine", 3'b111, 1, 0, 1);
    apply(0, 32'h100, 4'd4, 3'b001); check("R10 all off lower", 3'b000, 0, 0, 1);
    wl = 1;
    apply(1, 32'h100, 4'd4, 3'b001); check("R10 whitelist", 3'b000, 0, 0, 1);
    wl = 0; lk = 1;
    apply(1, 32'h100, 4'd4, 3'b010); check("R10 lockdown rw", 3'b011, 1, 0, 1);
    apply(1, 32'h100, 4'd4, 3'b100); check("R10 lockdown exec", 3'b000, 0, 0, 1);
    apply(0, 32'h100, 4'd4, 3'b001); check("R10 lockdown lower", 3'b000, 0, 0, 1);

    clear_all();
    cfg_q[3] = 8'h11; adr_q[3] = 32'h10;
    apply(0, 32'h40, 4'd4, 3'b001); check("R3 na4 read", 3'b001, 1, 3, 0);
    apply(0, 32'h40, 4'd4, 3'b010); check("R11 na4 write denied", 3'b001, 0, 3, 0);
    apply(0, 32'h42, 4'd4, 3'b001); check("R6 straddle", 3'b000, 0, 3, 0);
    apply(0, 32'h40, 4'd0, 3'b001); check("R12 size zero fits", 3'b001, 1, 3, 0);
    apply(0, 32'h41, 4'd0, 3'b001); check("R12 size zero straddles", 3'b000, 0, 3, 0);
    cfg_q[3] = 8'h01;
    apply(0, 32'h40, 4'd4, 3'b001); check("R1 off entry ignored", 3'b000, 0, 0, 1);

    clear_all();
    cfg_q[2] = 8'h1B; adr_q[2] = 32'h13;
    apply(0, 32'h50, 4'd8, 3'b010); check("R4 napot inside", 3'b011, 1, 2, 0);
    apply(0, 32'h5C, 4'd8, 3'b010); check("R4 napot straddle", 3'b000, 0, 2, 0);
    apply(0, 32'h3C, 4'd4, 3'b001); check("R4 napot below", 3'b000, 0, 0, 1);
    cfg_q[5] = 8'h11; adr_q[5] = 32'h10;
    apply(0, 32'h40, 4'd4, 3'b010); check("R5 lowest index wins", 3'b011, 1, 2, 0);

    clear_all();
    adr_q[0] = 32'h20; cfg_q[1] = 8'h0C; adr_q[1] = 32'h30;
    apply(0, 32'hBC, 4'd4, 3'b100); check("R2 tor inside", 3'b100, 1, 1, 0);
    apply(0, 32'h7C, 4'd4, 3'b100); check("R2 tor below", 3'b000, 0, 0, 1);
    adr_q[0] = 32'h30; adr_q[1] = 32'h20;
    apply(0, 32'h0, 4'd1, 3'b100); check("R2 tor collapse byte0", 3'b100, 1, 1, 0);
    apply(0, 32'h0, 4'd2, 3'b100); check("R2 tor collapse straddle", 3'b000, 0, 1, 0);

    clear_all();
    cfg_q[0] = 8'h19; adr_q[0] = 32'h1;
    apply(0, 32'hFFFF_FFFE, 4'd4, 3'b001); check("R12 wrap straddle", 3'b000, 0, 0, 0);

    clear_all();
    cfg_q[4] = 8'h91; adr_q[4] = 32'h10;
    apply(1, 32'h40, 4'd4, 3'b010); check("R7 locked machine", 3'b001, 0, 4, 0);
    cfg_q[4] = 8'h11;
    apply(1, 32'h40, 4'd4, 3'b010); check("R7 unlocked machine", 3'b111, 1, 4, 0);

    lk = 1;
    for (int k = 0; k < 16; k++) begin
      logic [3:0] kk;
      kk = 4'(k);
      cfg_q[4] = {kk[3], 2'b00, 2'b10, kk[0], kk[1], kk[2]};
      apply(1, 32'h40, 4'd4, 3'b001);
      check($sformatf("R8 key %0d", k), mach_tab(kk), (mach_tab(kk) & 3'b001) != 0, 4, 0);
      apply(0, 32'h40, 4'd4, 3'b001);
      check($sformatf("R9 key %0d", k), low_tab(kk), (low_tab(kk) & 3'b001) != 0, 4, 0);
    end

    for (int t = 0; t < 3000; t++) begin
      for (int i = 0; i < N; i++) begin
        cfg_q[i] = 8'($urandom);
        adr_q[i] = ($urandom % 5 == 0) ? $urandom : ($urandom % 48);
      end
      lk = ($urandom % 3 == 0);
      wl = ($urandom % 5 == 0);
      apply(1'($urandom), ($urandom % 8 == 0) ? $urandom : ($urandom % 200),
            4'($urandom % 10), 3'($urandom));
      check_ref("R11 random vs model");
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: got running exp finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule